// File: doc/BRIEF.md
# Multiplexor-Select Prefix Adder

This block adds two N-bit unsigned operands and a carry-in and returns an N-bit sum and a carry-out. It is purely combinational. Each bit position forms a select term, which is the XOR of the two operand bits, and a data term. A log-depth parallel-prefix tree then merges these terms. In the lower levels of the tree each node is a 2:1 multiplexor. If the select of the higher group is 1, the node passes the data term of the lower group; if it is 0, it keeps the data term of the higher group.

The data term can be operand `a`, operand `b`, or `a AND b`, chosen by a parameter. Any of the three is correct because the data term is never looked at while the select term is 1.

A second parameter sets how many lower tree levels use the multiplexor merge. The levels above them use the usual AND-OR propagate/generate merge. When the data term is a raw operand bit, one masking gate turns it into a true generate term at that switch point.

The carry-in enters the tree as an extra leaf below bit 0. That leaf always has select 0 and data equal to the carry-in. As a result, the data term of every prefix is already the carry into the next bit.

Top module: `mpa_adder`

## Requirements
- R1: For every parameter setting, `{cout, sum}` equals `a + b + cin` computed at N+1 bits.
- R2: The data-term source `Q_SRC` changes no output value. The encodings are 0 = operand `a`, 1 = operand `b`, 2 = `a AND b`.
- R3: `SEL_LEVELS` may take any value from 0 to ceil(log2(N+1)), and the outputs are the same for each value. This parameter is the number of lower tree levels built from multiplexor nodes; the rest use AND-OR nodes.
- R4: A carry-in of 1 ripples through the whole word when every bit position has `a_i XOR b_i = 1`. It then leaves `sum` all zeros and `cout` = 1.
- R5: Where `a_i XOR b_i = 1`, the carry out of bit i equals the carry into bit i. With `b = NOT a` and `cin = 0`, `sum` is all ones and `cout` is 0.
- R6: Where `a_i XOR b_i = 0`, the carry out of bit i equals `a_i` whatever carry comes in. With `a = b`, `sum` equals `(a << 1) | cin` truncated to N bits and `cout` equals `a[N-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The bench builds the block at two widths and makes one instance for every data-term source and every switch level at each width.

At 8 bits there are 3 × 5 instances. They are driven with every operand pair and both carry-in values. This covers every combination of select and data values that a multiplexor or AND-OR node can receive, whichever side of the switch point it is on.

At 32 bits there are 3 × 7 instances. They get a table of long-chain corner cases, directed ripple, kill and generate patterns, and random operands. These show that the conversion gate and the deep tree levels give the same carries at a realistic width.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

   // Source of the per-bit data term
   typedef enum logic [1:0] {
      QSRC_A   = 2'd0,
      QSRC_B   = 2'd1,
      QSRC_AND = 2'd2
   } qsrc_e;

   // Select / data pair carried through the prefix tree
   typedef struct packed {
      logic p;
      logic q;
   } pq_t;

   // Multiplexor merge: the select of the higher group picks the data term
   function automatic pq_t merge_sel(pq_t hi, pq_t lo);
      pq_t r;
      r.p = hi.p & lo.p;
      r.q = hi.p ? lo.q : hi.q;
      return r;
   endfunction

   // AND-OR merge on a propagate/generate pair
   function automatic pq_t merge_gen(pq_t hi, pq_t lo);
      pq_t r;
      r.p = hi.p & lo.p;
      r.q = hi.q | (hi.p & lo.q);
      return r;
   endfunction

   // Mask the data term so that it is a true generate (zero wherever select is set)
   function automatic pq_t to_generate(pq_t x);
      pq_t r;
      r.p = x.p;
      r.q = x.q & ~x.p;
      return r;
   endfunction

endpackage

// File: rtl/mpa_bit_cells.sv
module mpa_bit_cells #(
   parameter int             N     = 32,
   parameter mpa_pkg::qsrc_e Q_SRC = mpa_pkg::QSRC_A
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N-1:0] p,
   output logic [N-1:0] q
);
   assign p = a ^ b;

   generate
      if (Q_SRC == mpa_pkg::QSRC_A) begin : g_q_a
         assign q = a;
      end else if (Q_SRC == mpa_pkg::QSRC_B) begin : g_q_b
         assign q = b;
      end else begin : g_q_and
         assign q = a & b;
      end
   endgenerate

   // Whenever the select is clear, the data term must equal the true generate
   always_comb begin
      if (!$isunknown({a, b})) begin
         for (int i = 0; i < N; i++) begin
            if (!p[i]) begin
               assert_data_when_kept_R2: assert (q[i] == (a[i] & b[i]))
                  else $error("bit %0d data term differs from generate while select clear", i);
            end
         end
      end
   end

endmodule

// File: rtl/mpa_prefix_tree.sv
module mpa_prefix_tree #(
   parameter int M          = 33,
   parameter int SEL_LEVELS = 2,
   parameter bit NEED_CONV  = 1'b1
) (
   input  mpa_pkg::pq_t [M-1:0] leaf,
   output logic         [M-1:0] carry
);
   import mpa_pkg::*;

   localparam int LV = $clog2(M);

   generate
      for (genvar lv = 0; lv < LV; lv++) begin : g_lv
         localparam int DIST    = 1 << lv;
         localparam bit USE_SEL = (lv < SEL_LEVELS);
         localparam bit CONV_HERE = NEED_CONV && (lv == SEL_LEVELS);

         pq_t [M-1:0] raw;
         pq_t [M-1:0] src;
         pq_t [M-1:0] nxt;

         if (lv == 0) begin : g_from_leaf
            assign raw = leaf;
         end else begin : g_from_prev
            assign raw = g_lv[lv-1].nxt;
         end

         if (CONV_HERE) begin : g_conv
            always_comb begin
               for (int i = 0; i < M; i++) src[i] = to_generate(raw[i]);
            end
         end else begin : g_pass
            assign src = raw;
         end

         always_comb begin
            for (int i = 0; i < M; i++) begin
               if (i < DIST) begin
                  nxt[i] = src[i];
               end else if (USE_SEL) begin
                  nxt[i] = merge_sel(src[i], src[i-DIST]);
               end else begin
                  nxt[i] = merge_gen(src[i], src[i-DIST]);
               end
            end
         end
      end

      for (genvar k = 0; k < M; k++) begin : g_out
         assign carry[k] = g_lv[LV-1].nxt[k].q;
      end
   endgenerate

   // The carry-in leaf must reach the carry into bit 0 unchanged
   always_comb begin
      if (!$isunknown(leaf[0])) begin
         assert_cin_entry_R4: assert (carry[0] == leaf[0].q)
            else $error("carry into bit 0 does not follow carry-in leaf");
      end
   end

endmodule

// File: rtl/mpa_sum_stage.sv
module mpa_sum_stage #(
   parameter int N = 32
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] p,
   input  logic [N:0]   carry,
   output logic [N-1:0] sum
);
   assign sum = p ^ carry[N-1:0];

   // Per-bit carry behaviour seen between the bit cells and the tree
   always_comb begin
      if (!$isunknown({a, p, carry})) begin
         for (int i = 0; i < N; i++) begin
            if (p[i]) begin
               assert_propagate_R5: assert (carry[i+1] == carry[i])
                  else $error("bit %0d did not pass its carry through", i);
            end else begin
               assert_kill_or_gen_R6: assert (carry[i+1] == a[i])
                  else $error("bit %0d carry out does not follow operand", i);
            end
         end
      end
   end

endmodule

// File: rtl/mpa_adder.sv
module mpa_adder #(
   parameter int             N          = 32,
   parameter mpa_pkg::qsrc_e Q_SRC      = mpa_pkg::QSRC_A,
   parameter int             SEL_LEVELS = 2
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout
);
   import mpa_pkg::*;

   localparam int M         = N + 1;
   localparam int LV        = $clog2(M);
   localparam bit NEED_CONV = (Q_SRC != QSRC_AND) && (SEL_LEVELS < LV);

   generate
      if (N < 2) begin : g_bad_width
         $error("mpa_adder: N must be at least 2");
      end
      if (SEL_LEVELS < 0 || SEL_LEVELS > LV) begin : g_bad_levels
         $error("mpa_adder: SEL_LEVELS must lie in 0..ceil(log2(N+1))");
      end
   endgenerate

   logic [N-1:0] p_bit;
   logic [N-1:0] q_bit;
   pq_t  [M-1:0] leaf;
   logic [M-1:0] carry;

   mpa_bit_cells #(.N(N), .Q_SRC(Q_SRC)) u_cells (
      .a (a),
      .b (b),
      .p (p_bit),
      .q (q_bit)
   );

   // Leaf 0 carries the carry-in with a cleared select
   assign leaf[0].p = 1'b0;
   assign leaf[0].q = cin;
   generate
      for (genvar k = 0; k < N; k++) begin : g_leaf
         assign leaf[k+1].p = p_bit[k];
         assign leaf[k+1].q = q_bit[k];
      end
   endgenerate

   mpa_prefix_tree #(.M(M), .SEL_LEVELS(SEL_LEVELS), .NEED_CONV(NEED_CONV)) u_tree (
      .leaf  (leaf),
      .carry (carry)
   );

   mpa_sum_stage #(.N(N)) u_sum (
      .a     (a),
      .p     (p_bit),
      .carry (carry),
      .sum   (sum)
   );

   assign cout = carry[N];

   // Arithmetic check of the whole word
   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         assert_word_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (N+1)'(cin)))
            else $error("word sum mismatch");
      end
   end

endmodule

// File: tb/tb_mpa_adder.sv
`timescale 1ns/1ps
module tb_mpa_adder;

   localparam int W8  = 8;
   localparam int L8  = $clog2(W8 + 1);
   localparam int NV8 = 3 * (L8 + 1);
   localparam int W32 = 32;
   localparam int L32 = $clog2(W32 + 1);
   localparam int NV32 = 3 * (L32 + 1);
   localparam int WATCHDOG = 180000;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic        cin;
      logic [31:0] exp_sum;
      logic        exp_co;
   } vec_t;

   localparam int NTAB = 12;
   localparam vec_t TABLE [NTAB] = '{
      '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
      '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b1},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
      '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0},
      '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1},
      '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
      '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0},
      '{32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 32'hACF1_3568, 1'b0},
      '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0},
      '{32'hFFFF_0000, 32'h0000_FFFF, 1'b1, 32'h0000_0000, 1'b1},
      '{32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b1}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [W8-1:0]  a8, b8;
   logic           c8;
   logic [W32-1:0] a32, b32;
   logic           c32;

   logic [NV8-1:0][W8-1:0]   s8;
   logic [NV8-1:0]           co8;
   logic [NV32-1:0][W32-1:0] s32;
   logic [NV32-1:0]          co32;

   generate
      for (genvar qi = 0; qi < 3; qi++) begin : g8q
         for (genvar lv = 0; lv <= L8; lv++) begin : g8l
            mpa_adder #(.N(W8), .Q_SRC(mpa_pkg::qsrc_e'(qi)), .SEL_LEVELS(lv)) dut (
               .a    (a8),
               .b    (b8),
               .cin  (c8),
               .sum  (s8[qi*(L8+1)+lv]),
               .cout (co8[qi*(L8+1)+lv])
            );
         end
      end
      for (genvar qi = 0; qi < 3; qi++) begin : g32q
         for (genvar lv = 0; lv <= L32; lv++) begin : g32l
            mpa_adder #(.N(W32), .Q_SRC(mpa_pkg::qsrc_e'(qi)), .SEL_LEVELS(lv)) dut (
               .a    (a32),
               .b    (b32),
               .cin  (c32),
               .sum  (s32[qi*(L32+1)+lv]),
               .cout (co32[qi*(L32+1)+lv])
            );
         end
      end
   endgenerate

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;
   bit done = 1'b0;

   always @(posedge clk) cycles <= cycles + 1;

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // Compare every 8-bit variant with the expected word
   task automatic check8(input logic [W8-1:0] es, input logic ec, input string tag);
      bit bad = 1'b0;
      vectors++;
      for (int v = 0; v < NV8; v++) begin
         if (!bad && (s8[v] !== es || co8[v] !== ec)) begin
            bad = 1'b1;
            $display("FAIL %s w8 q=%0d lvl=%0d a=%h b=%h cin=%b: got %b_%h exp %b_%h",
                     tag, v / (L8+1), v % (L8+1), a8, b8, c8, co8[v], s8[v], ec, es);
         end
      end
      if (bad) miscompares++;
   endtask

   task automatic check32(input logic [W32-1:0] es, input logic ec, input string tag);
      bit bad = 1'b0;
      vectors++;
      for (int v = 0; v < NV32; v++) begin
         if (!bad && (s32[v] !== es || co32[v] !== ec)) begin
            bad = 1'b1;
            $display("FAIL %s w32 q=%0d lvl=%0d a=%h b=%h cin=%b: got %b_%h exp %b_%h",
                     tag, v / (L32+1), v % (L32+1), a32, b32, c32, co32[v], s32[v], ec, es);
         end
      end
      if (bad) miscompares++;
   endtask

   task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic ci,
                          input string tag);
      logic [32:0] ref_w;
      @(posedge clk);
      #1;
      a32 = a; b32 = b; c32 = ci;
      ref_w = {1'b0, a} + {1'b0, b} + 33'(ci);
      @(negedge clk);
      check32(ref_w[31:0], ref_w[32], tag);
   endtask

   initial begin
      a8 = '0; b8 = '0; c8 = 1'b0;
      a32 = '0; b32 = '0; c32 = 1'b0;
      repeat (3) @(posedge clk);
      // Reset state: zero operands give zero results (R1)
      @(negedge clk);
      check8('0, 1'b0, "R1 reset");
      check32('0, 1'b0, "R1 reset");
      rst = 1'b0;

      // Table walk (R1)
      for (int t = 0; t < NTAB; t++) begin
         @(posedge clk);
         #1;
         a32 = TABLE[t].a; b32 = TABLE[t].b; c32 = TABLE[t].cin;
         @(negedge clk);
         check32(TABLE[t].exp_sum, TABLE[t].exp_co, "R1 table");
      end

      // Full carry ripple from the carry-in (R4)
      apply32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R4 ripple");
      apply32(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R4 ripple");
      // All positions pass their carry with no carry-in (R5)
      apply32(32'h3C3C_A5A5, ~32'h3C3C_A5A5, 1'b0, "R5 propagate");
      // All positions kill or generate (R6)
      apply32(32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b1, "R6 kill/gen");
      apply32(32'h8000_0001, 32'h8000_0001, 1'b0, "R6 kill/gen");

      // Exhaustive 8-bit over every data source and switch level (R2, R3)
      for (int ci = 0; ci < 2; ci++) begin
         for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
               logic [8:0] ref_w;
               @(posedge clk);
               #1;
               a8 = ia[7:0]; b8 = ib[7:0]; c8 = ci[0];
               ref_w = {1'b0, ia[7:0]} + {1'b0, ib[7:0]} + 9'(ci);
               @(negedge clk);
               check8(ref_w[7:0], ref_w[8], "R2 R3 exhaustive");
            end
         end
      end

      // Random 32-bit operands (R1, R2, R3)
      for (int r = 0; r < 4000; r++) begin
         apply32($urandom, $urandom, 1'($urandom), "R1 R2 R3 random");
      end

      done = 1'b1;
      finish_run();
   end

   initial begin
      wait (cycles >= WATCHDOG);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run hung at cycle %0d, expected end before %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

endmodule